// File: doc/BRIEF.md
# Fixed-Priority Maskable Interrupt Controller

This block collects interrupt requests from a set of hardware sources. It keeps one request bit and one enable bit for each source, plus a single global disable flag. A one-cycle pulse on a source's request input sets its request bit. A maskable source is eligible only when its request bit is set, its enable bit is set and the global flag is clear. Source index 0 is the software break. It becomes eligible as soon as its request bit is set, whatever the flag or its enable bit hold. When any source is eligible, the lowest eligible index wins. The controller then offers that index to the CPU on a valid/acknowledge handshake.

When the CPU samples the offer, the controller sets the disable flag and clears the winning request bit on that same clock edge. Software sees the request bits, the enable bits and the flag as output ports and changes them through a single write strobe:

- A write to the enable bank loads every enable bit.
- A write to the request bank clears each bit written with 0 and leaves each bit written with 1 unchanged.
- A separate strobe loads the disable flag.

The default build has 18 sources: index 0 is the break, and 17 maskable sources sit above it (6 external and 11 internal).

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, every request bit and every enable bit is 0, the disable flag is 1 and irqValid is 0.
- R2: A 1 on hwReq[i] during a clock edge sets request bit i, and the bit is visible on reqBits after that edge.
- R3: A software write with swWrSel=0 clears each request bit i (i ≥ 1) whose swWrData[i] is 0, and leaves every bit whose data bit is 1 unchanged. A software write never sets a request bit.
- R4: When hwReq[i] and a software clear of bit i fall on the same edge, request bit i ends up set.
- R5: A software write with swWrSel=1 loads enBits with swWrData, which both sets and clears enable bits.
- R6: A maskable source i ≥ 1 is offered only when its request bit is 1, its enable bit is 1 and irqDisable is 0. Otherwise it never raises irqValid.
- R7: Source 0 (break) is offered whenever its request bit is 1, regardless of irqDisable and enBits[0]. Software writes never clear its request bit.
- R8: Among eligible sources, the lowest index is offered. irqVector carries that index in binary. The offer appears on the edge after the eligibility is visible on the outputs.
- R9: While irqValid is 1 and irqAck is 0, irqValid stays 1 and irqVector stays unchanged.
- R10: An edge with irqValid and irqAck both 1 sets irqDisable and clears the request bit of the offered index. It also drops irqValid for at least one cycle. A new hwReq for that index on the same edge keeps the request bit set.
- R11: flagWrEn loads irqDisable with flagWrData. On an edge that also accepts an acknowledge, the flag becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hwReq | input | NUM_SRC | Per-source request event pulses; bit 0 is break |
| swWrEn | input | 1 | Software write strobe for a bit bank |
| swWrSel | input | 1 | Bank select: 0 request bank (clear-only), 1 enable bank |
| swWrData | input | NUM_SRC | Software write data |
| flagWrEn | input | 1 | Software write strobe for the disable flag |
| flagWrData | input | 1 | New disable flag value |
| irqAck | input | 1 | CPU acknowledge of the current offer |
| reqBits | output | NUM_SRC | Request bits |
| enBits | output | NUM_SRC | Enable bits |
| irqDisable | output | 1 | Global disable flag |
| irqValid | output | 1 | An interrupt is offered |
| irqVector | output | VEC_W | Offered source index |

## Verification
The bench builds the controller with NUM_SRC=8, so the vector is 3 bits wide. With that size a sweep can cover all 256 request patterns, including the break bit. Each pattern runs against four enable masks: all on, all off and two mixed. Against each case the bench checks the winner, the hold, the acknowledge and the residual request bits. Directed sequences in the same small build reach the same-edge collisions: hardware set against software clear, and acknowledge against a flag write. They also cover a break raised while the flag is set and a software attempt to clear the break.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic {
    SEL_REQ = 1'b0,
    SEL_EN  = 1'b1
  } bankSel_e;

  typedef struct packed {
    logic capture;
    logic take;
  } ctrlStrobe_t;
endpackage

// File: rtl/irqc_datapath.sv
module irqc_datapath
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 18,
  parameter int VEC_W = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  logic [NUM_SRC-1:0] hwReq,
  input  logic               swWrEn,
  input  logic               swWrSel,
  input  logic [NUM_SRC-1:0] swWrData,
  input  logic               flagWrEn,
  input  logic               flagWrData,
  output logic [NUM_SRC-1:0] reqBits,
  output logic [NUM_SRC-1:0] enBits,
  output logic               irqDisable,
  output logic               anyElig,
  output logic [VEC_W-1:0]   vecReg
);
  logic [NUM_SRC-1:0] reqNext;
  logic [NUM_SRC-1:0] elig;
  logic [VEC_W-1:0]   winIdx;
  logic               reqWr;

  assign reqWr = swWrEn && (swWrSel == SEL_REQ);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    logic swClr;
    logic ackClr;
    if (i == 0) begin : g_brk
      assign swClr = 1'b0;
      assign elig[i] = reqBits[i];
    end else begin : g_mask
      assign swClr = reqWr && !swWrData[i];
      assign elig[i] = reqBits[i] && enBits[i] && !irqDisable;
    end
    assign ackClr = strobe.take && (vecReg == VEC_W'(i));
    assign reqNext[i] = hwReq[i] || (reqBits[i] && !swClr && !ackClr);
  end

  always_comb begin
    winIdx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (elig[i]) winIdx = VEC_W'(i);
    end
  end

  assign anyElig = |elig;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqBits    <= '0;
      enBits     <= '0;
      irqDisable <= 1'b1;
      vecReg     <= '0;
    end else begin
      reqBits <= reqNext;
      if (swWrEn && (swWrSel == SEL_EN)) enBits <= swWrData;
      if (strobe.take) irqDisable <= 1'b1;
      else if (flagWrEn) irqDisable <= flagWrData;
      if (strobe.capture) vecReg <= winIdx;
    end
  end
endmodule

// File: rtl/irqc_control.sv
module irqc_control
  import irqc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        anyElig,
  input  logic        irqAck,
  output ctrlStrobe_t strobe,
  output logic        irqValid
);
  typedef enum logic {ST_IDLE, ST_OFFER} state_e;
  state_e state;

  always_comb begin
    strobe.capture = (state == ST_IDLE) && anyElig;
    strobe.take    = (state == ST_OFFER) && irqAck;
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else if (strobe.capture) state <= ST_OFFER;
    else if (strobe.take) state <= ST_IDLE;
  end

  assign irqValid = (state == ST_OFFER);
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 18,
  localparam int VEC_W = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] hwReq,
  input  logic               swWrEn,
  input  logic               swWrSel,
  input  logic [NUM_SRC-1:0] swWrData,
  input  logic               flagWrEn,
  input  logic               flagWrData,
  input  logic               irqAck,
  output logic [NUM_SRC-1:0] reqBits,
  output logic [NUM_SRC-1:0] enBits,
  output logic               irqDisable,
  output logic               irqValid,
  output logic [VEC_W-1:0]   irqVector
);
  ctrlStrobe_t strobe;
  logic        anyElig;

  irqc_datapath #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .hwReq(hwReq),
    .swWrEn(swWrEn), .swWrSel(swWrSel), .swWrData(swWrData),
    .flagWrEn(flagWrEn), .flagWrData(flagWrData),
    .reqBits(reqBits), .enBits(enBits), .irqDisable(irqDisable),
    .anyElig(anyElig), .vecReg(irqVector)
  );

  irqc_control u_ctl (
    .clk(clk), .rstN(rstN), .anyElig(anyElig), .irqAck(irqAck),
    .strobe(strobe), .irqValid(irqValid)
  );
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int N = 18,
  parameter int W = 5
) (
  input logic         clk,
  input logic         rstN,
  input logic [N-1:0] hwReq,
  input logic         irqAck,
  input logic [N-1:0] reqBits,
  input logic [N-1:0] enBits,
  input logic         irqDisable,
  input logic         irqValid,
  input logic [W-1:0] irqVector
);
  logic [N-1:0] pReq, pEn, pElig;
  logic         pDis;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pReq <= '0; pEn <= '0; pDis <= 1'b1;
    end else begin
      pReq <= reqBits; pEn <= enBits; pDis <= irqDisable;
    end
  end

  assign pElig = pReq & ({N{!pDis}} & pEn | {{(N-1){1'b0}}, 1'b1});

  AST_HOLD_OFFER: assert property (@(posedge clk) disable iff (!rstN)
    irqValid && !irqAck |=> irqValid && $stable(irqVector)); // R9
  AST_ACK_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    irqValid && irqAck |=> irqDisable && !irqValid); // R10
  AST_ACK_CLEARS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    irqValid && irqAck && !hwReq[irqVector] |=> !reqBits[$past(irqVector)]); // R10
  AST_NO_SW_SET: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((reqBits & ~$past(reqBits) & ~$past(hwReq)) == '0)); // R3
  AST_BRK_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    reqBits[0] && !(irqValid && irqAck && irqVector == '0) |=> reqBits[0]); // R7
  AST_MASK_OK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqValid) |-> pElig[irqVector]); // R6
  AST_PRIO_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqValid) |-> ((pElig & ((N'(1) << irqVector) - N'(1))) == '0)); // R8
endmodule

bind irq_prio_ctrl irqc_checker #(.N(NUM_SRC), .W(VEC_W)) u_chk (
  .clk(clk), .rstN(rstN), .hwReq(hwReq), .irqAck(irqAck),
  .reqBits(reqBits), .enBits(enBits), .irqDisable(irqDisable),
  .irqValid(irqValid), .irqVector(irqVector)
);

// File: tb/tb_irq_prio_ctrl.sv
module tb_irq_prio_ctrl;
  localparam int N = 8;
  localparam int W = 3;

  logic         clk = 1'b0;
  logic         rstN;
  logic [N-1:0] hwReq, swWrData, reqBits, enBits;
  logic         swWrEn, swWrSel, flagWrEn, flagWrData, irqAck;
  logic         irqDisable, irqValid;
  logic [W-1:0] irqVector;

  int nTests = 0;
  int nFail  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  irq_prio_ctrl #(.NUM_SRC(N)) dut (
    .clk(clk), .rstN(rstN), .hwReq(hwReq), .swWrEn(swWrEn), .swWrSel(swWrSel),
    .swWrData(swWrData), .flagWrEn(flagWrEn), .flagWrData(flagWrData),
    .irqAck(irqAck), .reqBits(reqBits), .enBits(enBits),
    .irqDisable(irqDisable), .irqValid(irqValid), .irqVector(irqVector)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    hwReq = '0; swWrEn = 0; swWrSel = 0; swWrData = '0;
    flagWrEn = 0; flagWrData = 0; irqAck = 0;
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    #900000;
    if (!done) begin
      nFail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    idle();
    rstN = 0;
    tick(); tick();
    rstN = 1;
    check("R1 req", 32'(reqBits), 0);
    check("R1 en", 32'(enBits), 0);
    check("R1 dis", 32'(irqDisable), 1);
    check("R1 valid", 32'(irqValid), 0);

    // R2 and R3: flag is 1, so no offers for maskable sources
    hwReq = 8'h08; tick(); idle();
    check("R2 set", 32'(reqBits), 32'h08);
    swWrEn = 1; swWrSel = 0; swWrData = 8'hFF; tick(); idle();
    check("R3 write one keeps", 32'(reqBits), 32'h08);
    swWrEn = 1; swWrSel = 0; swWrData = 8'hF7; tick(); idle();
    check("R3 write zero clears", 32'(reqBits), 32'h00);
    // R4 collision
    hwReq = 8'h10; swWrEn = 1; swWrSel = 0; swWrData = 8'h00; tick(); idle();
    check("R4 hw wins", 32'(reqBits), 32'h10);
    // R5 enable bank
    swWrEn = 1; swWrSel = 1; swWrData = 8'hA5; tick(); idle();
    check("R5 load", 32'(enBits), 32'hA5);
    swWrEn = 1; swWrSel = 1; swWrData = 8'h5A; tick(); idle();
    check("R5 reload", 32'(enBits), 32'h5A);
    check("R6 flag masks", 32'(irqValid), 0);
    swWrEn = 1; swWrSel = 0; swWrData = 8'h00; tick(); idle();
    check("R3 clear all", 32'(reqBits), 0);

    // R7 break while flag set and enBits[0]=0
    hwReq = 8'h01; tick(); idle();
    swWrEn = 1; swWrSel = 0; swWrData = 8'h00; tick(); idle();
    check("R7 sw cannot clear", 32'(reqBits[0]), 1);
    check("R7 offered valid", 32'(irqValid), 1);
    check("R7 vector", 32'(irqVector), 0);
    // R11: ack together with flag write of 0
    irqAck = 1; flagWrEn = 1; flagWrData = 0; tick(); idle();
    check("R11 ack over flag write", 32'(irqDisable), 1);
    check("R10 break cleared", 32'(reqBits[0]), 0);
    flagWrEn = 1; flagWrData = 0; tick(); idle();
    check("R11 flag load", 32'(irqDisable), 0);

    // R10 ack with same-edge new hw event for the same index
    swWrEn = 1; swWrSel = 1; swWrData = 8'hFF; tick(); idle();
    hwReq = 8'h04; tick(); idle(); tick();
    check("R10 setup valid", 32'(irqValid), 1);
    irqAck = 1; hwReq = 8'h04; tick(); idle();
    check("R10 rehit keeps req", 32'(reqBits), 32'h04);
    check("R10 valid drops", 32'(irqValid), 0);
    swWrEn = 1; swWrSel = 0; swWrData = 8'h00; tick(); idle();

    // sweep over request patterns and enable masks
    for (int m = 0; m < 4; m++) begin
      for (int p = 0; p < 256; p++) begin
        logic [N-1:0] en, pat, elig;
        int w;
        en = (m == 0) ? 8'hFF : (m == 1) ? 8'h00 : (m == 2) ? 8'hAA : 8'h5C;
        pat = N'(p);
        elig = pat & (en | 8'h01);
        w = -1;
        for (int i = N - 1; i >= 0; i--) if (elig[i]) w = i;
        flagWrEn = 1; flagWrData = 0; swWrEn = 1; swWrSel = 1; swWrData = en;
        tick(); idle();
        hwReq = pat; tick(); idle();
        check("R2 sweep req", 32'(reqBits), 32'(pat));
        tick();
        if (w < 0) begin
          check("R6 sweep none", 32'(irqValid), 0);
        end else begin
          check("R8 sweep valid", 32'(irqValid), 1);
          check("R8 sweep vector", 32'(irqVector), 32'(w));
          tick();
          check("R9 hold valid", 32'(irqValid), 1);
          check("R9 hold vector", 32'(irqVector), 32'(w));
          irqAck = 1; tick(); idle();
          check("R10 sweep valid", 32'(irqValid), 0);
          check("R10 sweep flag", 32'(irqDisable), 1);
          check("R10 sweep req", 32'(reqBits), 32'(pat & ~(N'(1) << w)));
          tick();
          check("R6 sweep after ack", 32'(irqValid), 0);
        end
        swWrEn = 1; swWrSel = 0; swWrData = 8'h00; tick(); idle();
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule